// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block keeps a small record of the stores issued so far in the current dispatch group. When a later load is presented, it reports at once whether that load reads an address one of the recorded stores may have written. A scheduler uses the result to decide whether a no-op is needed to push the load into a later group. An access is described by two address operands and a byte size. The first operand is either a signed constant offset or a register tag. The second operand is always the tag of a base register. Sizes arrive already decoded as a 3-bit code.

A match is found in three ways. The first is equal operand pairs. The second is a commuted pair, where the load's register tags appear swapped relative to the store's. The third applies when both first operands are constants from the same base: the block checks numerically whether the two byte ranges overlap. A group-end input clears the record so the next group starts empty.

Top module: `ovl_detect`

## Requirements
- R1: After reset no store is recorded, so any load query gives `ld_hit` = 0.
- R2: A load whose first operand (constant flag and 16-bit value) and base tag both equal those of a recorded store gives `ld_hit` = 1.
- R3: A load whose first operand is a register tag equal to a recorded store's base tag, and whose base tag equals that store's register-tag first operand, gives `ld_hit` = 1.
- R4: With equal base tags and both first operands constant, if the store offset is below the load offset, `ld_hit` = 1 exactly when the store offset plus the store size exceeds the load offset. Offsets are signed and the sum does not wrap.
- R5: In the same constant case with the store offset not below the load offset, `ld_hit` = 1 exactly when the load offset plus the load size exceeds the store offset.
- R6: Size code 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8, and 4 through 7 mean 16 bytes.
- R7: Base tags that differ, or first operands that differ where the two are not both constants, give no match.
- R8: `ld_hit` is combinational. It is 0 whenever `ld_valid` is 0 or no store is recorded.
- R9: A store with `st_valid` = 1 is recorded at the clock edge and affects queries from the next cycle on. Up to 5 recorded stores are all compared at once.
- R10: A store that arrives while 5 stores are already recorded is dropped. Entries recorded earlier are kept.
- R11: `group_end` = 1 clears every entry at the clock edge. A store offered in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| group_end | input | 1 | Closes the dispatch group and clears all entries |
| st_valid | input | 1 | A store is issued this cycle |
| st_a_const | input | 1 | Store first operand is a constant offset |
| st_a_val | input | 16 | Store first operand: signed offset, or register tag in the low 8 bits |
| st_b_tag | input | 8 | Store base register tag |
| st_size | input | 3 | Store size code |
| ld_valid | input | 1 | A load is being queried |
| ld_a_const | input | 1 | Load first operand is a constant offset |
| ld_a_val | input | 16 | Load first operand: signed offset, or register tag in the low 8 bits |
| ld_b_tag | input | 8 | Load base register tag |
| ld_size | input | 3 | Load size code |
| ld_hit | output | 1 | Load may read a byte written by a recorded store |

## Verification
The store-load pairs are chosen to separate the three match paths. Exact register pairs and exact constant pairs test R2. Swapped tags test R3, and mixed constant/tag operands test R7. Offset pairs sitting just inside and just outside each range test which side of the inequality is applied, and whether the store's or the load's size is used. Negative offsets and offsets near the top of the signed range expose narrow or unsigned arithmetic, and the size codes above 4 show how they decode. Directed sequences then fill all five entries, overflow them, and clear them in the same cycle as a store, which shows how capacity, entry lifetime and same-cycle priority behave.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int OFF_W = 16;
  localparam int TAG_W = 8;
  localparam int SZ_W  = 3;
  localparam int BYTES_W = 5;
  localparam int EXT_W = OFF_W + 2;

  typedef struct packed {
    logic              a_const;
    logic [OFF_W-1:0]  a_val;
    logic [TAG_W-1:0]  b_tag;
    logic [SZ_W-1:0]   size;
  } acc_t;

  function automatic logic [BYTES_W-1:0] size_bytes(input logic [SZ_W-1:0] code);
    logic [BYTES_W-1:0] b;
    case (code)
      3'd0:    b = 5'd1;
      3'd1:    b = 5'd2;
      3'd2:    b = 5'd4;
      3'd3:    b = 5'd8;
      default: b = 5'd16;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/ovl_store_table.sv
module ovl_store_table
  import ovl_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             group_end,
  input  logic             st_valid,
  input  acc_t             st_acc,
  output acc_t [DEPTH-1:0] ent,
  output logic [DEPTH-1:0] ent_vld
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] wr_en;
  logic             full;
  logic             accept;
  acc_t [DEPTH-1:0] ent_q;

  assign full   = (cnt_q == CW'(DEPTH));
  assign accept = st_valid && !group_end && !full;

  // next-state
  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (group_end) begin
      cnt_d = '0;
      vld_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + CW'(1);
      vld_d = vld_q | wr_en;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign wr_en[i] = accept && (cnt_q == CW'(i));
      always_ff @(posedge clk) begin
        if (wr_en[i]) ent_q[i] <= st_acc;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign ent     = ent_q;
  assign ent_vld = vld_q;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(DEPTH)) && ($countones(vld_q) == int'(cnt_q)));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> (vld_q == '0));

  assert_append_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !group_end && !full) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

  assert_drop_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !group_end && full) |=> $stable(vld_q));
endmodule

// File: rtl/ovl_entry_cmp.sv
module ovl_entry_cmp
  import ovl_pkg::*;
(
  input  acc_t  ent,
  input  logic  ent_vld,
  input  acc_t  ld,
  output logic  match
);
  logic                    exact, swapped, both_const, same_base, overlap;
  logic signed [EXT_W-1:0] s_off, l_off, s_end, l_end;

  assign exact   = (ent.a_const == ld.a_const) && (ent.a_val == ld.a_val) &&
                   (ent.b_tag == ld.b_tag);

  assign swapped = !ent.a_const && !ld.a_const &&
                   (ld.a_val == {{(OFF_W-TAG_W){1'b0}}, ent.b_tag}) &&
                   (ent.a_val == {{(OFF_W-TAG_W){1'b0}}, ld.b_tag});

  assign both_const = ent.a_const && ld.a_const;
  assign same_base  = (ent.b_tag == ld.b_tag);

  assign s_off = EXT_W'(signed'(ent.a_val));
  assign l_off = EXT_W'(signed'(ld.a_val));
  assign s_end = s_off + signed'({{(EXT_W-BYTES_W){1'b0}}, size_bytes(ent.size)});
  assign l_end = l_off + signed'({{(EXT_W-BYTES_W){1'b0}}, size_bytes(ld.size)});

  always_comb begin
    if (s_off < l_off) overlap = (s_end > l_off);
    else               overlap = (l_end > s_off);
  end

  assign match = ent_vld && (exact || swapped || (both_const && same_base && overlap));
endmodule

// File: rtl/ovl_detect.sv
module ovl_detect
  import ovl_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             group_end,
  input  logic             st_valid,
  input  logic             st_a_const,
  input  logic [OFF_W-1:0] st_a_val,
  input  logic [TAG_W-1:0] st_b_tag,
  input  logic [SZ_W-1:0]  st_size,
  input  logic             ld_valid,
  input  logic             ld_a_const,
  input  logic [OFF_W-1:0] ld_a_val,
  input  logic [TAG_W-1:0] ld_b_tag,
  input  logic [SZ_W-1:0]  ld_size,
  output logic             ld_hit
);
  acc_t             st_acc, ld_acc;
  acc_t [DEPTH-1:0] ent;
  logic [DEPTH-1:0] ent_vld;
  logic [DEPTH-1:0] ent_match;

  assign st_acc = '{a_const: st_a_const, a_val: st_a_val, b_tag: st_b_tag, size: st_size};
  assign ld_acc = '{a_const: ld_a_const, a_val: ld_a_val, b_tag: ld_b_tag, size: ld_size};

  ovl_store_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .group_end(group_end),
    .st_valid (st_valid),
    .st_acc   (st_acc),
    .ent      (ent),
    .ent_vld  (ent_vld)
  );

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      ovl_entry_cmp u_cmp (
        .ent    (ent[i]),
        .ent_vld(ent_vld[i]),
        .ld     (ld_acc),
        .match  (ent_match[i])
      );
    end
  endgenerate

  assign ld_hit = ld_valid && (|ent_match);

  assert_hit_needs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> ld_valid);

  assert_hit_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> (|ent_vld));

  assert_match_only_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_match & ~ent_vld) == '0);
endmodule

// File: tb/tb_ovl_detect.sv
`timescale 1ns/1ps
module tb_ovl_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        group_end, st_valid, st_a_const, ld_valid, ld_a_const;
  logic [15:0] st_a_val, ld_a_val;
  logic [7:0]  st_b_tag, ld_b_tag;
  logic [2:0]  st_size, ld_size;
  logic        ld_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ovl_detect dut (
    .clk(clk), .rst_n(rst_n), .group_end(group_end),
    .st_valid(st_valid), .st_a_const(st_a_const), .st_a_val(st_a_val),
    .st_b_tag(st_b_tag), .st_size(st_size),
    .ld_valid(ld_valid), .ld_a_const(ld_a_const), .ld_a_val(ld_a_val),
    .ld_b_tag(ld_b_tag), .ld_size(ld_size), .ld_hit(ld_hit)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        sac;
    logic [15:0] sa;
    logic [7:0]  sb;
    logic [2:0]  ss;
    logic        lac;
    logic [15:0] la;
    logic [7:0]  lb;
    logic [2:0]  ls;
    logic        exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{4'd2,  1'b0, 16'd5,     8'd7, 3'd0, 1'b0, 16'd5,     8'd7, 3'd0, 1'b1}, // R2 reg pair
    '{4'd2,  1'b1, 16'd8,     8'd3, 3'd2, 1'b1, 16'd8,     8'd3, 3'd2, 1'b1}, // R2 const pair
    '{4'd3,  1'b0, 16'd9,     8'd4, 3'd2, 1'b0, 16'd4,     8'd9, 3'd2, 1'b1}, // R3 swapped
    '{4'd7,  1'b0, 16'd9,     8'd4, 3'd2, 1'b0, 16'd10,    8'd4, 3'd2, 1'b0}, // R7 reg differs
    '{4'd7,  1'b1, 16'd0,     8'd1, 3'd2, 1'b1, 16'd0,     8'd2, 3'd2, 1'b0}, // R7 base differs
    '{4'd4,  1'b1, 16'd0,     8'd3, 3'd2, 1'b1, 16'd3,     8'd3, 3'd0, 1'b1}, // R4 inside
    '{4'd4,  1'b1, 16'd0,     8'd3, 3'd2, 1'b1, 16'd4,     8'd3, 3'd0, 1'b0}, // R4 edge
    '{4'd5,  1'b1, 16'd2,     8'd3, 3'd2, 1'b1, 16'd0,     8'd3, 3'd1, 1'b0}, // R5 edge
    '{4'd5,  1'b1, 16'd2,     8'd3, 3'd0, 1'b1, 16'd0,     8'd3, 3'd2, 1'b1}, // R5 inside
    '{4'd5,  1'b1, 16'd5,     8'd3, 3'd0, 1'b1, 16'd5,     8'd3, 3'd3, 1'b1}, // R5 equal offs
    '{4'd6,  1'b1, 16'd0,     8'd3, 3'd4, 1'b1, 16'd15,    8'd3, 3'd0, 1'b1}, // R6 16B inside
    '{4'd6,  1'b1, 16'd0,     8'd3, 3'd4, 1'b1, 16'd16,    8'd3, 3'd0, 1'b0}, // R6 16B edge
    '{4'd6,  1'b1, 16'd0,     8'd3, 3'd7, 1'b1, 16'd15,    8'd3, 3'd0, 1'b1}, // R6 code 7
    '{4'd4,  1'b1, 16'hFFFC,  8'd3, 3'd3, 1'b1, 16'd2,     8'd3, 3'd0, 1'b1}, // R4 negative
    '{4'd5,  1'b1, 16'hFFFC,  8'd3, 3'd0, 1'b1, 16'hFFF8,  8'd3, 3'd2, 1'b0}, // R5 negative
    '{4'd7,  1'b1, 16'd4,     8'd3, 3'd2, 1'b0, 16'd4,     8'd3, 3'd2, 1'b0}, // R7 mixed kind
    '{4'd4,  1'b1, 16'h7FF8,  8'd3, 3'd4, 1'b1, 16'h7FFF,  8'd3, 3'd0, 1'b1}  // R4 no wrap
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ld_hit=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic end_group();
    @(negedge clk); group_end = 1'b1;
    @(negedge clk); group_end = 1'b0;
  endtask

  task automatic put_store(input logic ac, input logic [15:0] a, input logic [7:0] b,
                           input logic [2:0] s);
    @(negedge clk);
    st_valid = 1'b1; st_a_const = ac; st_a_val = a; st_b_tag = b; st_size = s;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic set_load(input logic v, input logic ac, input logic [15:0] a,
                          input logic [7:0] b, input logic [2:0] s);
    ld_valid = v; ld_a_const = ac; ld_a_val = a; ld_b_tag = b; ld_size = s;
    #1;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; group_end = 1'b0; st_valid = 1'b0; st_a_const = 1'b0;
    st_a_val = '0; st_b_tag = '0; st_size = '0;
    ld_valid = 1'b0; ld_a_const = 1'b0; ld_a_val = '0; ld_b_tag = '0; ld_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    set_load(1'b1, 1'b0, 16'd0, 8'd0, 3'd0);
    check(ld_hit, 1'b0, "R1 empty after reset");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      end_group();
      put_store(VT[i].sac, VT[i].sa, VT[i].sb, VT[i].ss);
      set_load(1'b1, VT[i].lac, VT[i].la, VT[i].lb, VT[i].ls);
      check(ld_hit, VT[i].exp, $sformatf("R%0d vector %0d", VT[i].req, i));
      set_load(1'b0, 1'b0, 16'd0, 8'd0, 3'd0);
    end

    // R8: ld_valid low masks a real match
    end_group();
    put_store(1'b0, 16'd5, 8'd7, 3'd0);
    set_load(1'b0, 1'b0, 16'd5, 8'd7, 3'd0);
    check(ld_hit, 1'b0, "R8 ld_valid low");

    // R9: store not visible in its own cycle, visible after the edge
    end_group();
    @(negedge clk);
    st_valid = 1'b1; st_a_const = 1'b1; st_a_val = 16'd40; st_b_tag = 8'd9; st_size = 3'd2;
    set_load(1'b1, 1'b1, 16'd40, 8'd9, 3'd2);
    check(ld_hit, 1'b0, "R9 same-cycle store not seen");
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    check(ld_hit, 1'b1, "R9 store seen next cycle");
    set_load(1'b0, 1'b0, 16'd0, 8'd0, 3'd0);

    // R9/R10: fill five, overflow with a sixth
    end_group();
    for (int k = 1; k <= 5; k++) put_store(1'b1, 16'd0, 8'(k), 3'd0);
    put_store(1'b1, 16'd0, 8'd6, 3'd0);
    set_load(1'b1, 1'b1, 16'd0, 8'd5, 3'd0);
    check(ld_hit, 1'b1, "R9 fifth entry compared");
    set_load(1'b1, 1'b1, 16'd0, 8'd1, 3'd0);
    check(ld_hit, 1'b1, "R10 first entry kept when full");
    set_load(1'b1, 1'b1, 16'd0, 8'd6, 3'd0);
    check(ld_hit, 1'b0, "R10 sixth store dropped");
    set_load(1'b0, 1'b0, 16'd0, 8'd0, 3'd0);

    // R11: group_end with a store in the same cycle
    @(negedge clk);
    group_end = 1'b1;
    st_valid = 1'b1; st_a_const = 1'b1; st_a_val = 16'd0; st_b_tag = 8'd20; st_size = 3'd0;
    @(negedge clk);
    group_end = 1'b0; st_valid = 1'b0;
    set_load(1'b1, 1'b1, 16'd0, 8'd20, 3'd0);
    check(ld_hit, 1'b0, "R11 same-cycle store dropped");
    set_load(1'b1, 1'b1, 16'd0, 8'd1, 3'd0);
    check(ld_hit, 1'b0, "R11 old entries cleared");

    // R10/R11: after clearing, five entries can be recorded again
    set_load(1'b0, 1'b0, 16'd0, 8'd0, 3'd0);
    for (int k = 30; k < 35; k++) put_store(1'b0, 16'd2, 8'(k), 3'd0);
    set_load(1'b1, 1'b0, 16'd2, 8'd34, 3'd0);
    check(ld_hit, 1'b1, "R11 capacity restored after clear");
    set_load(1'b0, 1'b0, 16'd0, 8'd0, 3'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule